// File: doc/BRIEF.md
# SPI Command-Register Transmitter

This block sends a short, write-only SPI transaction of one to four bytes from a single 32-bit command word. It does not use a transmit FIFO. Software or a neighbouring controller sets the command word, a two-bit byte-count field, the word width and the bit order. With command mode enabled, a one-cycle start strobe captures all of them. The block then shifts the frame out on `mosi` under its own serial clock. Nothing is received, so the block has no serial input.

The frame is right-justified in the command word and rounded up to whole words of the selected width. In most-significant-first order the highest used bit leaves first. In least-significant-first order bit 0 leaves first. After the final falling serial-clock edge, an optional dummy delay of zero or more controller cycles runs. The block then raises a one-cycle frame-end flag. Chip select is not driven here.

Top module: `spi_cmd_tx`

## Requirements
- R1: After reset `sclk`, `mosi`, `busy` and `frame_end` are all low.
- R2: A start strobe (`go`) is taken only when `cmd_mode_en` is 1 and the block is idle. With `cmd_mode_en` at 0 the strobe causes no serial clock edge and `busy` stays low.
- R3: The frame length in bits is (`cmd_cnt_m1`+1) bytes, rounded up to a whole number of words, times 8. Word width codes: `word_sel` 00 = 8-bit, 01 = 16-bit, 10 or 11 = 32-bit. Exactly that many rising `sclk` edges occur per frame.
- R4: With `lsb_first` = 0, the bits go out from bit (length−1) of `cmd_word` down to bit 0. A 16-bit, four-byte frame therefore sends the upper halfword first.
- R5: With `lsb_first` = 1, the bits go out from bit 0 of `cmd_word` up to bit (length−1).
- R6: `sclk` idles low and toggles every `HALF_DIV` controller cycles while shifting. `mosi` is set while `sclk` is low and does not change on a rising edge. Rising edges are at least 2·`HALF_DIV` cycles apart.
- R7: `frame_end` is a one-cycle pulse that rises exactly 1+`dummy_dly` cycles after the final falling `sclk` edge. A delay of 0 gives the cycle right after that edge.
- R8: `busy` is high from the cycle after an accepted start until `frame_end` rises, and is low in the `frame_end` cycle. A start strobe or a changed `cmd_word` while busy does not alter the frame in flight and starts no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_word | input | 32 | Command bits, right-justified |
| cmd_cnt_m1 | input | 2 | Number of command bytes minus one |
| cmd_mode_en | input | 1 | Command mode enable |
| word_sel | input | 2 | Word width: 00 8-bit, 01 16-bit, 1x 32-bit |
| lsb_first | input | 1 | 1 = least significant bit first |
| dummy_dly | input | DLY_W | Idle cycles between last edge and frame end |
| go | input | 1 | Start strobe |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| frame_end | output | 1 | One-cycle completion flag |

## Verification
The assertions assume that reset is applied before the first start. They also assume that the count, width, order and delay inputs matter only in the cycle a start is accepted, since the block captures them there. The stimulus changes every input on the falling controller edge and pulses `go` for exactly one cycle. It holds the frame settings steady across each accepted start. The only inputs changed during a frame are the deliberate `go` and `cmd_word` changes that exercise the capture rule.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

  typedef enum logic [1:0] {
    WS_8   = 2'b00,
    WS_16  = 2'b01,
    WS_32  = 2'b10,
    WS_32X = 2'b11
  } wsel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_DWELL = 2'b10
  } state_e;

  // bytes per word for a width code
  function automatic logic [2:0] f_word_bytes(input logic [1:0] wsel);
    case (wsel_e'(wsel))
      WS_8:    return 3'd1;
      WS_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // frame length in bits: byte count rounded up to whole words
  function automatic logic [5:0] f_frame_bits(input logic [1:0] cnt_m1,
                                              input logic [1:0] wsel);
    logic [3:0] wb;
    logic [3:0] bytes;
    logic [3:0] rnd;
    wb    = {1'b0, f_word_bytes(wsel)};
    bytes = {2'b00, cnt_m1} + 4'd1;
    rnd   = (bytes + wb - 4'd1) & ~(wb - 4'd1);
    return {rnd[2:0], 3'b000};
  endfunction

  // position in the command word of the k-th bit sent
  function automatic logic [4:0] f_bit_index(input logic [5:0] k,
                                             input logic [5:0] nbits,
                                             input logic       lsb);
    logic [5:0] t;
    t = lsb ? k : (nbits - 6'd1 - k);
    return t[4:0];
  endfunction

endpackage

// File: rtl/spicmd_tick_gen.sv
module spicmd_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HALF_DIV > 1) begin : g_gap
      // half-period ticks never come back to back
      p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/spicmd_bit_seq.sv
module spicmd_bit_seq
  import spicmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] cnt_m1,
  input  logic [1:0] wsel,
  input  logic       lsb_in,
  input  logic       adv,
  output logic [4:0] bit_idx,
  output logic       last_bit,
  output logic [5:0] frame_bits
);
  logic [5:0] k_q;
  logic [5:0] nbits_q;
  logic       lsb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q     <= '0;
      nbits_q <= '0;
      lsb_q   <= 1'b0;
    end else if (load) begin
      k_q     <= '0;
      nbits_q <= f_frame_bits(cnt_m1, wsel);
      lsb_q   <= lsb_in;
    end else if (adv && !last_bit) begin
      k_q <= k_q + 6'd1;
    end
  end

  assign last_bit   = (k_q == nbits_q - 6'd1);
  assign bit_idx    = f_bit_index(k_q, nbits_q, lsb_q);
  assign frame_bits = nbits_q;

  // bit counter never walks past the frame
  p_k_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nbits_q != 6'd0) |-> (k_q < nbits_q));

endmodule

// File: rtl/spicmd_dwell.sv
module spicmd_dwell #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] dly_in,
  input  logic             run,
  output logic             expired
);
  logic [DLY_W-1:0] cnt_q;

  assign expired = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= dly_in;
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  p_dwell_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx
  import spicmd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DLY_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cmd_word,
  input  logic [1:0]       cmd_cnt_m1,
  input  logic             cmd_mode_en,
  input  logic [1:0]       word_sel,
  input  logic             lsb_first,
  input  logic [DLY_W-1:0] dummy_dly,
  input  logic             go,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             frame_end
);
  state_e      state_q;
  logic [31:0] cmd_q;
  logic        sclk_q;
  logic        frame_end_q;
  logic [5:0]  rises_q;

  // named events
  logic       accept;
  logic       tick;
  logic       rise_ev;
  logic       fall_ev;
  logic       final_fall;
  logic       dwell_done;
  logic [4:0] bit_idx;
  logic       last_bit;
  logic [5:0] frame_bits;

  assign accept     = go && cmd_mode_en && (state_q == ST_IDLE);
  assign rise_ev    = tick && !sclk_q;
  assign fall_ev    = tick && sclk_q;
  assign final_fall = fall_ev && last_bit;

  spicmd_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == ST_SHIFT),
    .tick (tick)
  );

  spicmd_bit_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .cnt_m1    (cmd_cnt_m1),
    .wsel      (word_sel),
    .lsb_in    (lsb_first),
    .adv       (fall_ev),
    .bit_idx   (bit_idx),
    .last_bit  (last_bit),
    .frame_bits(frame_bits)
  );

  spicmd_dwell #(.DLY_W(DLY_W)) u_dwell (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .dly_in (dummy_dly),
    .run    (state_q == ST_DWELL),
    .expired(dwell_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cmd_q       <= '0;
      sclk_q      <= 1'b0;
      frame_end_q <= 1'b0;
    end else begin
      frame_end_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cmd_q   <= cmd_word;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick)       sclk_q  <= ~sclk_q;
          if (final_fall) state_q <= ST_DWELL;
        end
        ST_DWELL: begin
          if (dwell_done) begin
            frame_end_q <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // rising edge tally for the length check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rises_q <= '0;
    else if (accept)   rises_q <= '0;
    else if (rise_ev)  rises_q <= rises_q + 6'd1;
  end

  assign sclk      = sclk_q;
  assign mosi      = (state_q == ST_SHIFT) && cmd_q[bit_idx];
  assign busy      = (state_q != ST_IDLE);
  assign frame_end = frame_end_q;

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (!busy && $past(busy)));

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  p_mode_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !cmd_mode_en && !busy) |=> !busy);

  p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (rises_q == frame_bits));

endmodule

// File: tb/sim_spi_cmd_tx.sv
`timescale 1ns/1ps
module sim_spi_cmd_tx;
  localparam int HD = 2;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cmd_word = '0;
  logic [1:0]    cmd_cnt_m1 = '0;
  logic          cmd_mode_en = 1'b0;
  logic [1:0]    word_sel = '0;
  logic          lsb_first = 1'b0;
  logic [DW-1:0] dummy_dly = '0;
  logic          go = 1'b0;
  logic          sclk, mosi, busy, frame_end;

  int checks = 0;
  int errors = 0;

  spi_cmd_tx #(.HALF_DIV(HD), .DLY_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_cnt_m1(cmd_cnt_m1),
    .cmd_mode_en(cmd_mode_en), .word_sel(word_sel), .lsb_first(lsb_first),
    .dummy_dly(dummy_dly), .go(go), .sclk(sclk), .mosi(mosi), .busy(busy),
    .frame_end(frame_end)
  );

  always #5 clk = ~clk;

  // line monitor, runs on falling controller edges
  int          cyc = 0;
  int          rises = 0;
  int          last_rise = 0;
  int          last_fall = 0;
  int          fe_cnt = 0;
  int          fe_cyc = 0;
  int          gap_bad = 0;
  int          hold_bad = 0;
  logic [63:0] cap = '0;
  logic        prev_sclk = 1'b0;
  logic        prev_mosi = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sclk === 1'b1 && prev_sclk === 1'b0) begin
      cap = {cap[62:0], mosi};
      rises = rises + 1;
      if (rises > 1 && (cyc - last_rise) < 2 * HD) gap_bad = gap_bad + 1;
      last_rise = cyc;
      if (mosi !== prev_mosi) hold_bad = hold_bad + 1;
    end
    if (sclk === 1'b0 && prev_sclk === 1'b1) last_fall = cyc;
    if (frame_end === 1'b1) begin
      fe_cnt = fe_cnt + 1;
      fe_cyc = cyc;
    end
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int exp_bits(input logic [1:0] cn, input logic [1:0] ws);
    int wb;
    int words;
    wb = (ws == 2'b00) ? 1 : ((ws == 2'b01) ? 2 : 4);
    words = (cn + 1 + wb - 1) / wb;
    return words * wb * 8;
  endfunction

  function automatic logic [63:0] exp_stream(input logic [31:0] c, input int nb, input logic lb);
    logic [63:0] s;
    s = '0;
    for (int i = 0; i < nb; i++) s = {s[62:0], (lb ? c[i] : c[nb - 1 - i])};
    return s;
  endfunction

  task automatic pulse_go();
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_end(input int base_fe);
    int n;
    n = 0;
    while (fe_cnt == base_fe && n < 3000) begin
      @(posedge clk);
      #2;
      n++;
    end
  endtask

  // one full frame with all line checks
  task automatic run_frame(input string tag, input logic [31:0] c, input logic [1:0] cn,
                           input logic [1:0] ws, input logic lb, input int d);
    int base_r;
    int base_fe;
    int nb;
    logic [63:0] mask;
    @(negedge clk);
    cmd_word = c; cmd_cnt_m1 = cn; word_sel = ws; lsb_first = lb;
    dummy_dly = DW'(d); cmd_mode_en = 1'b1;
    base_r = rises; base_fe = fe_cnt;
    nb = exp_bits(cn, ws);
    mask = (64'd1 << nb) - 64'd1;
    pulse_go();
    #1;
    chk({tag, " R8 busy after start"}, busy, 1);
    wait_end(base_fe);
    chk({tag, " R7 one frame end"}, fe_cnt - base_fe, 1);
    chk({tag, " R3 edge count"}, rises - base_r, nb);
    chk({tag, lb ? " R5 lsb order" : " R4 msb order"}, cap & mask, exp_stream(c, nb, lb));
    chk({tag, " R7 end delay"}, fe_cyc - last_fall, 1 + d);
    chk({tag, " R8 idle at end"}, busy, 0);
    chk({tag, " R6 idle clock low"}, sclk, 0);
  endtask

  task automatic t_reset_r1();
    #1;
    chk("R1 sclk", sclk, 0);
    chk("R1 mosi", mosi, 0);
    chk("R1 busy", busy, 0);
    chk("R1 frame_end", frame_end, 0);
  endtask

  task automatic t_mode_off_r2();
    int base_r;
    @(negedge clk);
    cmd_mode_en = 1'b0; cmd_word = 32'hFFFF_FFFF; cmd_cnt_m1 = 2'd3;
    base_r = rises;
    pulse_go();
    #1;
    chk("R2 no busy with mode off", busy, 0);
    repeat (30) @(negedge clk);
    #1;
    chk("R2 no clock edges with mode off", rises - base_r, 0);
    chk("R2 still idle", busy, 0);
  endtask

  task automatic t_restart_r8();
    int base_r;
    int base_fe;
    @(negedge clk);
    cmd_word = 32'h0000_00A5; cmd_cnt_m1 = 2'd0; word_sel = 2'b00;
    lsb_first = 1'b0; dummy_dly = '0; cmd_mode_en = 1'b1;
    base_r = rises; base_fe = fe_cnt;
    pulse_go();
    repeat (6) @(negedge clk);
    cmd_word = 32'h0000_00FF; cmd_cnt_m1 = 2'd3;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    wait_end(base_fe);
    chk("R8 frame kept length", rises - base_r, 8);
    chk("R8 frame kept data", cap & 64'hFF, 64'hA5);
    repeat (40) @(negedge clk);
    #1;
    chk("R8 no second frame", rises - base_r, 8);
    chk("R8 single frame end", fe_cnt - base_fe, 1);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_r1();
    run_frame("msb8x3",  32'h11C3_5A7E, 2'd2, 2'b00, 1'b0, 0);
    run_frame("lsb8x2",  32'hFFFF_9A3C, 2'd1, 2'b00, 1'b1, 0);
    run_frame("w16x3",   32'hB1E2_4D07, 2'd2, 2'b01, 1'b0, 0);
    run_frame("w16x4",   32'h1234_ABCD, 2'd3, 2'b01, 1'b0, 2);
    run_frame("w16x1l",  32'h0000_8001, 2'd0, 2'b01, 1'b1, 0);
    run_frame("w32x1",   32'h8421_0F3C, 2'd0, 2'b10, 1'b1, 0);
    run_frame("w32xc",   32'hDEAD_0001, 2'd1, 2'b11, 1'b0, 1);
    run_frame("dly5",    32'h0000_0069, 2'd0, 2'b00, 1'b0, 5);
    run_frame("dly15",   32'h0000_C0DE, 2'd1, 2'b00, 1'b1, 15);
    t_mode_off_r2();
    t_restart_r8();
    checks++;
    if (gap_bad != 0) begin errors++; $display("FAIL R6 edge spacing got %0d expected 0", gap_bad); end
    checks++;
    if (hold_bad != 0) begin errors++; $display("FAIL R6 data hold got %0d expected 0", hold_bad); end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule